// File: doc/BRIEF.md
# Table-Driven Reprogrammable State Machine

This block is a finite state machine whose whole control algorithm sits in two small writable tables, so it can be changed while the chip runs and nothing has to be resynthesized. The first table, the selector table, has one entry per state. That entry names the few external condition inputs that matter in that state. A replacement multiplexer routes those inputs onto a narrow group of condition bits P1..P3. The second table, the transition RAM, is addressed by the current state code joined with those condition bits. Each word holds the next-state code and the output vector.

Narrowing eight inputs to three condition bits before they reach the memory makes the transition RAM a fraction of the size it would need if every input went straight into the address. Because the state code takes a full address field of its own, no two states can ever produce the same address.

Both tables are loaded through one plain write port. While `load_mode` is high, the machine is held in its initial state. The block has no data stream, so every pin is a plain level-sensitive control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `rfsm_top`

## Requirements
- R1: While `rst_n` is low, `state_o` is 0 (the initial state) and `y_o` is 0. The selector table is cleared, so every slot is disabled.
- R2: On every rising edge where `load_mode` is high, `state_o` becomes 0 and `y_o` becomes 0, whatever the inputs and table contents are.
- R3: On a rising edge with `load_mode` low, the transition RAM is read at address {state_o, P3, P2, P1}, with P1 in bit 0 and the state in bits 5:3. `state_o` then takes bits 2:0 of that word and `y_o` takes bits 6:3.
- R4: The selector entry of a state has one 4-bit slot per condition bit. Slot k (P(k+1)) sits in bits 4k+3:4k. Bits 4k+2:4k hold the input index, where index i selects x[i] (x1 is x[0]). Bit 4k+3 enables the slot.
- R5: A disabled slot drives its condition bit to 0.
- R6: Writing a transition word changes the next state and outputs of the affected address from then on.
- R7: Writing a selector entry changes which inputs steer that state from then on.
- R8: With `wr_en` high, a rising edge writes `wr_data[6:0]` to transition address `wr_addr` when `wr_tbl` is 0. When `wr_tbl` is 1, it writes `wr_data[11:0]` to selector entry `wr_addr[2:0]`, but only if `wr_addr[5:3]` is 0; otherwise that selector write is ignored.
- R9: Inputs that the current state's selector entry does not name have no effect on the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_mode | input | 1 | Holds the machine in the initial state while the tables are loaded |
| wr_en | input | 1 | Table write strobe |
| wr_tbl | input | 1 | 0 selects the transition RAM, 1 selects the selector table |
| wr_addr | input | 6 | Write address |
| wr_data | input | 12 | Write data |
| x | input | 8 | External condition inputs x1..x8 (x[0] is x1) |
| state_o | output | 3 | Current state code |
| y_o | output | 4 | Registered output vector y1..y4 |

## Verification
The tables are read combinationally and the state and outputs are registered. As a result, `state_o` and `y_o` reflect inputs applied before a rising edge one edge later, and the same holds for the hold forced by `load_mode`. The driver applies the inputs at a falling edge and computes the expected pair from its own copy of the tables. After the next rising edge, it queues that pair. The monitor compares it at the following falling edge, half a period after the registers change. Table writes take effect at the edge that carries them, so the bench checks their effect only on later transitions.

// File: rtl/rfsm_pkg.sv
package rfsm_pkg;
  typedef enum logic {
    TBL_TRANS = 1'b0,
    TBL_SEL   = 1'b1
  } tbl_e;
endpackage

// File: rtl/rfsm_sel_table.sv
module rfsm_sel_table #(
  parameter int STATE_W = 3,
  parameter int N_IN    = 8,
  parameter int N_P     = 3,
  parameter int ADDR_W  = 6,
  localparam int IDX_W  = $clog2(N_IN),
  localparam int SLOT_W = IDX_W + 1,
  localparam int ENT_W  = N_P * SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [ENT_W-1:0]   wr_data,
  input  logic [STATE_W-1:0] cur_state,
  input  logic [N_IN-1:0]    x,
  output logic [N_P-1:0]     p
);
  localparam int N_STATE = 1 << STATE_W;

  logic [ENT_W-1:0] ent_q [N_STATE];
  logic [ENT_W-1:0] cur_ent;
  logic             addr_ok;

  assign addr_ok = (wr_addr[ADDR_W-1:STATE_W] == '0);
  assign cur_ent = ent_q[cur_state];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_STATE; i++) ent_q[i] <= '0;
    end else if (wr_en && addr_ok) begin
      ent_q[wr_addr[STATE_W-1:0]] <= wr_data;
    end
  end

  for (genvar k = 0; k < N_P; k++) begin : g_slot
    logic [IDX_W-1:0] idx;
    logic             en;
    assign idx = cur_ent[k*SLOT_W +: IDX_W];
    assign en  = cur_ent[k*SLOT_W + IDX_W];
    always_comb begin
      p[k] = 1'b0;
      if (en && (int'(idx) < N_IN)) p[k] = x[idx];
    end
  end

  // R8
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr_ok) |=> (cur_state != $past(wr_addr[STATE_W-1:0])) || (cur_ent == $past(wr_data)));
endmodule

// File: rtl/rfsm_trans_ram.sv
module rfsm_trans_ram #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // R6
  trans_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_addr != $past(wr_addr)) || (rd_data == $past(wr_data)));
endmodule

// File: rtl/rfsm_state_reg.sv
module rfsm_state_reg #(
  parameter int STATE_W = 3,
  parameter int N_OUT   = 4,
  parameter logic [STATE_W-1:0] INIT_STATE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_mode,
  input  logic [STATE_W-1:0] nxt_state,
  input  logic [N_OUT-1:0]   nxt_y,
  output logic [STATE_W-1:0] state_q,
  output logic [N_OUT-1:0]   y_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= INIT_STATE;
      y_q     <= '0;
    end else if (load_mode) begin
      state_q <= INIT_STATE;
      y_q     <= '0;
    end else begin
      state_q <= nxt_state;
      y_q     <= nxt_y;
    end
  end

  // R2
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_mode |=> (state_q == INIT_STATE) && (y_q == '0));
endmodule

// File: rtl/rfsm_top.sv
module rfsm_top #(
  parameter int STATE_W = 3,
  parameter int N_IN    = 8,
  parameter int N_P     = 3,
  parameter int N_OUT   = 4,
  parameter logic [STATE_W-1:0] INIT_STATE = '0,
  localparam int ADDR_W = STATE_W + N_P,
  localparam int WORD_W = STATE_W + N_OUT,
  localparam int ENT_W  = N_P * ($clog2(N_IN) + 1),
  localparam int WR_W   = (ENT_W > WORD_W) ? ENT_W : WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_mode,
  input  logic               wr_en,
  input  logic               wr_tbl,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WR_W-1:0]    wr_data,
  input  logic [N_IN-1:0]    x,
  output logic [STATE_W-1:0] state_o,
  output logic [N_OUT-1:0]   y_o
);
  import rfsm_pkg::*;

  logic [N_P-1:0]    p;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic              wr_trans, wr_sel;

  assign wr_trans = wr_en && (tbl_e'(wr_tbl) == TBL_TRANS);
  assign wr_sel   = wr_en && (tbl_e'(wr_tbl) == TBL_SEL);

  rfsm_sel_table #(.STATE_W(STATE_W), .N_IN(N_IN), .N_P(N_P), .ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data[ENT_W-1:0]), .cur_state(state_o), .x(x), .p(p)
  );

  assign rd_addr = {state_o, p};

  rfsm_trans_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_trans), .wr_addr(wr_addr),
    .wr_data(wr_data[WORD_W-1:0]), .rd_addr(rd_addr), .rd_data(rd_word)
  );

  rfsm_state_reg #(.STATE_W(STATE_W), .N_OUT(N_OUT), .INIT_STATE(INIT_STATE)) u_st (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode),
    .nxt_state(rd_word[STATE_W-1:0]), .nxt_y(rd_word[WORD_W-1:STATE_W]),
    .state_q(state_o), .y_q(y_o)
  );

  if (WR_W > WORD_W) begin : g_unused_trans
    logic unused_hi_trans;
    assign unused_hi_trans = ^wr_data[WR_W-1:WORD_W];
  end
  if (WR_W > ENT_W) begin : g_unused_sel
    logic unused_hi_sel;
    assign unused_hi_sel = ^wr_data[WR_W-1:ENT_W];
  end

  // R3
  state_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_mode |=> state_o == $past(rd_word[STATE_W-1:0]));
  // R3
  out_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_mode |=> y_o == $past(rd_word[WORD_W-1:STATE_W]));
endmodule

// File: tb/rfsm_top_test.sv
module rfsm_top_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, load_mode, wr_en, wr_tbl;
  logic [5:0]  wr_addr;
  logic [11:0] wr_data;
  logic [7:0]  x;
  logic [2:0]  state_o;
  logic [3:0]  y_o;

  rfsm_top uut (
    .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .wr_en(wr_en), .wr_tbl(wr_tbl),
    .wr_addr(wr_addr), .wr_data(wr_data), .x(x), .state_o(state_o), .y_o(y_o)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [6:0]  ttab [64];
  logic [11:0] stab [8];
  logic [2:0]  mstate;
  logic [7:0]  lf = 8'h5A;

  typedef struct { logic [6:0] v; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {state,y} actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares half a period after the registers move
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, {state_o, y_o}, e.v);
    end
  end

  function automatic logic [6:0] lookup(logic [2:0] s, logic [7:0] xv);
    logic [2:0] p;
    for (int k = 0; k < 3; k++)
      p[k] = stab[s][4*k+3] ? xv[stab[s][4*k +: 3]] : 1'b0;
    return ttab[{s, p}];
  endfunction

  task automatic wr(bit tbl, logic [5:0] a, logic [11:0] d);
    wr_en = 1; wr_tbl = tbl; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(logic [7:0] xv, string tag);
    logic [6:0] w;
    x = xv;
    if (load_mode) w = 7'h00;
    else begin
      w = lookup(mstate, xv);
      w = {w[6:3], w[2:0]};
    end
    @(posedge clk);
    q.push_back('{ {w[2:0], w[6:3]}, tag });
    mstate = w[2:0];
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; load_mode = 1; wr_en = 0; wr_tbl = 0; wr_addr = '0; wr_data = '0; x = '0;
    mstate = 3'd0;
    for (int a = 0; a < 64; a++) begin
      logic [2:0] s, p;
      s = a[5:3]; p = a[2:0];
      ttab[a] = {4'((s * 3 + p) & 15), 3'((s + p + 1) & 7)};
    end
    for (int s = 0; s < 8; s++) stab[s] = '0;
    stab[0] = {4'h0, 4'h0, 4'b1_000};              // P1 = x1
    stab[1] = {4'b1_010, 4'b1_001, 4'b1_000};      // x1,x2,x3
    stab[2] = {4'b1_111, 4'b1_110, 4'b1_101};      // x6,x7,x8
    stab[5] = {4'b1_100, 4'b1_011, 4'b1_101};      // x6,x4,x5
    repeat (3) @(negedge clk);
    check("R1 reset", {state_o, y_o}, 7'h00);
    rst_n = 1;
    @(negedge clk);
    // R8: load both tables through the write port
    for (int a = 0; a < 64; a++) wr(1'b0, 6'(a), {5'h0, ttab[a]});
    for (int s = 0; s < 8; s++) wr(1'b1, 6'(s), stab[s]);
    // R2: held while loading mode is on
    for (int i = 0; i < 4; i++) step(8'hFF - 8'(i), "R2 hold");
    load_mode = 0; mstate = 3'd0;
    // R9: state 0 only looks at x1
    step(8'hFE, "R9 unselected inputs");
    // R3 R4 R5: free run with pseudo-random inputs
    for (int i = 0; i < 60; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf, "R3 R4 R5 transition");
    end
    // R2: back to load mode
    load_mode = 1;
    step(8'h55, "R2 hold again");
    // R6: rewrite a transition word
    ttab[6'b000_001] = {4'hA, 3'd5};
    wr(1'b0, 6'b000_001, {5'h0, ttab[6'b000_001]});
    step(8'h00, "R2 hold");
    load_mode = 0; mstate = 3'd0;
    step(8'h01, "R6 rewritten word");
    // R7: state 0 now steered by x8 instead of x1
    load_mode = 1;
    step(8'h00, "R2 hold");
    stab[0] = {4'h0, 4'h0, 4'b1_111};
    wr(1'b1, 6'd0, stab[0]);
    // R8: selector write with nonzero upper address bits is ignored
    wr(1'b1, 6'h08, 12'h000);
    load_mode = 0; mstate = 3'd0;
    step(8'h80, "R7 R8 new selector");
    load_mode = 1;
    step(8'h00, "R2 hold");
    load_mode = 0; mstate = 3'd0;
    step(8'h7F, "R7 x1 no longer used");
    for (int i = 0; i < 20; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      step(lf, "R3 R7 transition");
    end
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule